// File: doc/BRIEF.md
# Binary to Decimal Digit Memory Writer

This unit takes an 8-bit unsigned number and a 12-bit base address, splits the number into its hundreds, tens and ones decimal digits, and stores those digits in a byte-wide memory through one write port. A single-cycle start pulse launches the operation. The unit then issues three back-to-back write beats at consecutive addresses and marks the end with a one-cycle completion pulse.

Each digit is written as a whole byte whose upper nibble is zero. The most significant digit goes to the lowest address. Address arithmetic is done in 12 bits, so a run that begins near the top of the 4096-byte space wraps around to address zero. The number and base address are captured when start is accepted, so the requester may change them afterwards.

Top module: `bcd_mem_writer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the unit returns to idle: busy, done and mem_we are all 0 after that edge, even if a write sequence was in progress.
- R2: A start sampled high while busy is 0 makes the next cycle the first write beat: mem_we=1, mem_addr=base, and mem_wdata equal to the hundreds digit.
- R3: The second write beat follows immediately: mem_we=1, mem_addr=base+1, and mem_wdata equal to the tens digit.
- R4: The third write beat follows immediately: mem_we=1, mem_addr=base+2, and mem_wdata equal to the ones digit.
- R5: Every written byte holds a value from 0 to 9 with bits 7:4 zero, and the hundreds digit never exceeds 2.
- R6: Write addresses are computed modulo 4096. For example, a base of 0xFFF writes to 0xFFF, 0x000 and 0x001.
- R7: done is high for exactly one cycle, namely the cycle right after the third write beat. In the cycle after that, busy is 0.
- R8: busy is 1 from the first write beat through the done cycle, and 0 otherwise.
- R9: A start that arrives while busy is 1, including during the done cycle, is ignored. The running sequence keeps its addresses and data, and no new sequence begins.
- R10: mem_we is 1 only during the three write beats. It is 0 when idle and during the done cycle.
- R11: The number and base address are captured on the cycle start is accepted. Changes to those inputs while busy have no effect on the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; accepted only when idle |
| value | input | 8 | Unsigned number to convert |
| base_addr | input | 12 | Address for the hundreds digit |
| busy | output | 1 | Sequence in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 8 | Memory write data, one decimal digit |
| mem_we | output | 1 | Memory write enable |

## Verification
The unit takes one cycle to accept a start. The three write beats then appear 1, 2 and 3 cycles after the accepting edge, done appears after 4 cycles, and the unit is idle again after 5. The bench drives inputs on the falling edge and samples on each of the following falling edges, so every check lands in the cycle its result is due. In the disturbed runs, the bench changes the number and base address and pulses start during a write beat and again during the done cycle. It then confirms that the remaining beats still carry the captured operands and that the unit is idle one cycle later.

// File: rtl/bcd_pkg.sv
// Shared definitions for the decimal digit writer.
// Assumes digits are 4-bit binary coded decimal.
package bcd_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_DONE  = 2'd2
    } phase_t;
endpackage

// File: rtl/bcd_split.sv
// Combinational binary-to-decimal splitter using shift-and-add-3.
// Assumes DIGITS is large enough to hold 2**VAL_W - 1.
// digits[0] holds the ones digit.
module bcd_split
    import bcd_pkg::*;
#(
    parameter int VAL_W  = 8,
    parameter int DIGITS = 3
) (
    input  logic [VAL_W-1:0]                bin,
    output logic [DIGITS-1:0][DIGIT_W-1:0]  digits
);
    localparam int BCD_W = DIGITS * DIGIT_W;

    logic [BCD_W-1:0] acc;

    // Correct each digit and shift in one binary bit per step.
    always_comb begin
        acc = '0;
        for (int i = VAL_W - 1; i >= 0; i--) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (acc[d*DIGIT_W +: DIGIT_W] >= DIGIT_W'(5))
                    acc[d*DIGIT_W +: DIGIT_W] = acc[d*DIGIT_W +: DIGIT_W] + DIGIT_W'(3);
            end
            acc = {acc[BCD_W-2:0], bin[i]};
        end
    end

    // Slice the accumulator into digit fields.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign digits[g] = acc[g*DIGIT_W +: DIGIT_W];
    end
endmodule

// File: rtl/bcd_write_seq.sv
// Write sequencer: captures the operands on start and walks one write beat
// per digit, most significant digit first, at consecutive wrapping addresses.
// It then raises done for one cycle.
// Assumes the memory accepts one write per cycle without stalling.
module bcd_write_seq
    import bcd_pkg::*;
#(
    parameter int VAL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int DIGITS = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [VAL_W-1:0]                value,
    input  logic [ADDR_W-1:0]               base_addr,
    input  logic [DIGITS-1:0][DIGIT_W-1:0]  digits,
    output logic [VAL_W-1:0]                value_q,
    output logic                            busy,
    output logic                            done,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic [DATA_W-1:0]               mem_wdata,
    output logic                            mem_we
);
    localparam int BEAT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(DIGITS - 1);

    phase_t              phase;
    logic [BEAT_W-1:0]   beat;
    logic [ADDR_W-1:0]   base_q;
    logic [BEAT_W-1:0]   sel;

    // Phase, beat counter and operand capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            beat    <= '0;
            value_q <= '0;
            base_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_WRITE;
                        beat    <= '0;
                        value_q <= value;
                        base_q  <= base_addr;
                    end
                end
                PH_WRITE: begin
                    if (beat == LAST_BEAT) phase <= PH_DONE;
                    else                   beat  <= beat + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Output decode: the beat picks the digit from the top down.
    always_comb begin
        sel       = LAST_BEAT - beat;
        busy      = (phase != PH_IDLE);
        done      = (phase == PH_DONE);
        mem_we    = (phase == PH_WRITE);
        mem_addr  = base_q + ADDR_W'(beat);
        mem_wdata = {{(DATA_W-DIGIT_W){1'b0}}, digits[sel]};
    end

    // R2 / R8: an accepted start leads straight into a write beat.
    assert_start_enters_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && mem_we && mem_addr == $past(base_addr)));

    // R3 / R6: consecutive beats step the address by one, modulo the width.
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && beat != LAST_BEAT) |=> (mem_we && mem_addr == $past(mem_addr) + 1'b1));

    // R5: written bytes are decimal digits.
    assert_digit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata <= DATA_W'(9)));

    // R7: done lasts one cycle and is followed by idle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10: no write during done or idle.
    assert_we_only_beats_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && !done));

    // R9: while busy and not finishing, the unit stays busy regardless of start.
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R11: operands do not move during a sequence.
    assert_operands_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(value_q) && $stable(base_q)));
endmodule

// File: rtl/bcd_mem_writer.sv
// Top level: writes the decimal digits of an 8-bit number to three
// consecutive byte addresses, hundreds first, then pulses done.
// Assumes exclusive use of the memory write port while busy.
module bcd_mem_writer
    import bcd_pkg::*;
#(
    parameter int VAL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int DIGITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VAL_W-1:0]  value,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);
    logic [VAL_W-1:0]               value_q;
    logic [DIGITS-1:0][DIGIT_W-1:0] digits;

    bcd_split #(.VAL_W(VAL_W), .DIGITS(DIGITS)) u_split (
        .bin    (value_q),
        .digits (digits)
    );

    bcd_write_seq #(
        .VAL_W(VAL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIGITS(DIGITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .value     (value),
        .base_addr (base_addr),
        .digits    (digits),
        .value_q   (value_q),
        .busy      (busy),
        .done      (done),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    // R1: reset leaves the unit idle with no write.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_we));
endmodule

// File: tb/bcd_mem_writer_test.sv
module bcd_mem_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int WATCHDOG_CYCLES = 20000;

    // {value, base, hundreds, tens, ones}
    localparam logic [43:0] VEC [NVEC] = '{
        {8'd0,   12'h200, 8'd0, 8'd0, 8'd0},
        {8'd255, 12'h300, 8'd2, 8'd5, 8'd5},
        {8'd100, 12'h123, 8'd1, 8'd0, 8'd0},
        {8'd99,  12'h456, 8'd0, 8'd9, 8'd9},
        {8'd9,   12'h010, 8'd0, 8'd0, 8'd9},
        {8'd10,  12'h7FE, 8'd0, 8'd1, 8'd0},
        {8'd128, 12'hABC, 8'd1, 8'd2, 8'd8},
        {8'd37,  12'hFFD, 8'd0, 8'd3, 8'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  value = '0;
    logic [11:0] base_addr = '0;
    logic        busy, done, mem_we;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bcd_mem_writer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .value(value),
        .base_addr(base_addr), .busy(busy), .done(done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(!busy, req, "busy", int'(busy), 0);
        chk(!done, req, "done", int'(done), 0);
        chk(!mem_we, req, "mem_we", int'(mem_we), 0);
    endtask

    task automatic chk_beat(input string req, input logic [11:0] a, input logic [7:0] d);
        chk(mem_we === 1'b1, req, "mem_we", int'(mem_we), 1);
        chk(busy === 1'b1 && done === 1'b0, req, "busy/done", int'({busy, done}), 2);
        chk(mem_addr === a, req, "mem_addr", int'(mem_addr), int'(a));
        chk(mem_wdata === d, req, "mem_wdata", int'(mem_wdata), int'(d));
        chk(mem_wdata[7:4] == 4'd0 && mem_wdata <= 8'd9, "R5", "digit range", int'(mem_wdata), 9);
    endtask

    // Drive one sequence; disturb pulses start and alters operands while busy.
    task automatic run_seq(input logic [7:0] v, input logic [11:0] b,
                           input logic [7:0] h, input logic [7:0] t,
                           input logic [7:0] o, input bit disturb);
        @(negedge clk);
        start = 1'b1; value = v; base_addr = b;
        @(negedge clk);
        start = 1'b0;
        chk_beat("R2", b, h);
        if (h > 8'd2) chk(0, "R5", "hundreds", int'(h), 2);
        if (disturb) begin
            start = 1'b1; value = ~v; base_addr = b + 12'h055;   // R9 R11
        end
        @(negedge clk);
        start = 1'b0;
        chk_beat("R3", b + 12'd1, t);
        @(negedge clk);
        chk_beat("R4", b + 12'd2, o);
        @(negedge clk);
        chk(done === 1'b1, "R7", "done", int'(done), 1);
        chk(mem_we === 1'b0, "R10", "mem_we in done", int'(mem_we), 0);
        chk(busy === 1'b1, "R8", "busy in done", int'(busy), 1);
        if (disturb) start = 1'b1;                                 // R9 during done
        @(negedge clk);
        start = 1'b0;
        chk_idle("R7");
        if (disturb) begin
            @(negedge clk);
            chk_idle("R9");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        while (cycles < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with start held high during reset.
        start = 1'b1; value = 8'd42; base_addr = 12'h100;
        repeat (3) @(negedge clk);
        chk_idle("R1");
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // Main table walk: R2 R3 R4 R5 R6 R7 R8 R10.
        for (int i = 0; i < NVEC; i++) begin
            run_seq(VEC[i][43:36], VEC[i][35:24], VEC[i][23:16],
                    VEC[i][15:8], VEC[i][7:0], (i % 3) == 1);
        end

        // R6: base at the very top of the address space.
        run_seq(8'd123, 12'hFFF, 8'd1, 8'd2, 8'd3, 1'b0);
        run_seq(8'd246, 12'hFFE, 8'd2, 8'd4, 8'd6, 1'b1);

        // R1: synchronous reset in the middle of a sequence.
        @(negedge clk);
        start = 1'b1; value = 8'd77; base_addr = 12'h040;
        @(negedge clk);
        start = 1'b0;
        chk(mem_we === 1'b1, "R2", "mem_we before reset", int'(mem_we), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // R11 R2: start right after a reset works with fresh operands.
        run_seq(8'd200, 12'h5A0, 8'd2, 8'd0, 8'd0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule